// File: doc/BRIEF.md
# Sample-rate timing event generator

This block produces the input-side and output-side timing strobes that pace a set of sample-rate converter or command channels. Every channel owns two 16-bit timing fields, one for its input events and one for its output events. A field names a timing source and a divider code. The source is either one of five reference tick streams (three audio reference clocks and two baud-rate generator outputs) divided by a ratio from a fixed nonuniform table, or the word-select line of one serial port, whose rising edge is passed on.

Channels are packed two to a 32-bit register. Software writes the registers through a simple write port, and separately enables each divided reference. Every strobe is a single system-clock pulse. The reference ticks are expected as single-cycle enables in the system clock domain, and the word-select lines are sampled in that same domain.

Top module: `rate_timing_gen`

## Requirements
- R1: With NUM_CH=4 the address map is: 0..1 input timing registers, 2..3 output timing registers, 4 divider enable. Channel c uses register c/2; even channels occupy bits [15:0] and odd channels occupy bits [31:16]. In each 16-bit field, bits [11:8] hold the source and bits [4:0] hold the divider code. All other field bits are ignored.
- R2: Source codes 0, 1 and 2 select reference ticks A, B and C (ref_tick[0..2]). Source codes 3 and 4 select baud generators A and B (ref_tick[3..4]). A divided path counts only cycles in which its selected tick is high.
- R3: Divider codes 0..3 give ratios 2, 4, 6 and 8. Each code from 4 to 28 multiplies the previous ratio alternately by 3/2 (even codes) and by 4/3 (odd codes), ending at 49152. Code 29 gives 98304. A divided path emits exactly one one-cycle strobe per ratio ticks.
- R4: The divider enable register holds the enable for source s at bit s+1. While that bit is clear, a channel using source s emits nothing and its count is held at zero.
- R5: Divider codes 30 and 31 are reserved; a divided channel using them emits no strobe.
- R6: Source code 6+n selects serial port n. A rising edge on ws_in[n] gives a one-cycle strobe in the cycle after the edge is sampled.
- R7: When pin_share[n] is set for the selected port n, ports 1, 2 and 9 follow word-select 0, port 4 follows word-select 3, and port 8 follows word-select 7. Any other port follows its own line, and the port's own line is ignored while it is remapped.
- R8: A write to a timing register restarts the counts of both channels in it. It also suppresses their strobes for that cycle, even if a terminal count or a word-select edge coincides. The first strobe after the write comes ratio ticks later. Writing the enable register with a bit newly set starts that count from zero.
- R9: After reset all fields and enables are zero and every strobe output is low.
- R10: Source code 5, and source codes that name a port at or beyond NUM_PORTS, never produce a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| ref_tick | input | 5 | Reference tick enables: A, B, C, baud A, baud B |
| ws_in | input | NUM_PORTS | Serial port word-select lines |
| pin_share | input | NUM_PORTS | Per-port word-select sharing mode |
| in_strobe | output | NUM_CH | Input timing event per channel |
| out_strobe | output | NUM_CH | Output timing event per channel |

## Verification
A register write and a terminal count can land on the same edge for a channel of that register. The bench schedules a rewrite of a running ratio-4 channel on the exact edge of its second terminal count. It then expects that edge to produce no pulse and the next pulse to come four ticks after the write. A word-select edge that coincides with a write is covered by the same suppression rule, and an in-RTL property checks that every write cycle is followed by a quiet strobe.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  localparam int CNT_W    = 17;
  localparam int NUM_REF  = 5;
  localparam int WS_BASE  = 6;
  localparam int LAST_CODE = 29;
  localparam logic [15:0] FIELD_MASK = 16'h0F1F;

  // Divide ratio for a 5-bit code; 0 means reserved.
  function automatic logic [CNT_W-1:0] code_ratio(input logic [4:0] code);
    int c;
    int r;
    c = int'(code);
    if (c == 0)               r = 2;
    else if (c == LAST_CODE)  r = 98304;
    else if (c > LAST_CODE)   r = 0;
    else if (c % 2 == 1)      r = 1 << ((c + 3) / 2);
    else                      r = 3 << (c / 2);
    return CNT_W'(r);
  endfunction

  // Word-select line used by port n when it shares pins.
  function automatic int share_remap(input int n);
    case (n)
      1, 2, 9: return 0;
      4:       return 3;
      8:       return 7;
      default: return n;
    endcase
  endfunction

endpackage

// File: rtl/rtg_ws_edge.sv
module rtg_ws_edge #(
  parameter int NUM_PORTS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] ws_in,
  output logic [NUM_PORTS-1:0] ws_rise
);

  logic [NUM_PORTS-1:0] ws_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ws_q <= '0;
    else        ws_q <= ws_in;
  end

  assign ws_rise = ws_in & ~ws_q;

  // R6: a held-high line gives one event, never two in a row
  a_r6_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_rise != '0) |=> ((ws_rise & $past(ws_rise)) == '0));

endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [31:0]              wr_data,
  output logic [NUM_CH-1:0][15:0]  in_field,
  output logic [NUM_CH-1:0][15:0]  out_field,
  output logic [NUM_REF-1:0]       div_en,
  output logic [NUM_CH-1:0]        in_restart,
  output logic [NUM_CH-1:0]        out_restart
);

  localparam int NREG    = (NUM_CH + 1) / 2;
  localparam int EN_ADDR = 2 * NREG;
  localparam logic [31:0] REG_MASK = {FIELD_MASK, FIELD_MASK};

  logic [NREG-1:0][31:0] in_reg, out_reg;
  logic [NREG-1:0]       in_hit, out_hit;
  logic                  en_hit;
  logic [NUM_REF-1:0]    en_q;

  assign en_hit = wr_en && (wr_addr == ADDR_W'(EN_ADDR));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign in_hit[i]  = wr_en && (wr_addr == ADDR_W'(i));
    assign out_hit[i] = wr_en && (wr_addr == ADDR_W'(NREG + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_reg[i]  <= '0;
        out_reg[i] <= '0;
      end else begin
        if (in_hit[i])  in_reg[i]  <= wr_data & REG_MASK;
        if (out_hit[i]) out_reg[i] <= wr_data & REG_MASK;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign in_field[c]    = in_reg[c/2][16*(c%2) +: 16];
    assign out_field[c]   = out_reg[c/2][16*(c%2) +: 16];
    assign in_restart[c]  = in_hit[c/2];
    assign out_restart[c] = out_hit[c/2];
  end

  // enable for source s sits at bit s+1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_hit) en_q <= wr_data[NUM_REF:1];
  end
  assign div_en = en_q;

  // R1: a write lands masked in the addressed register
  a_r1_field_capture: assert property (@(posedge clk) disable iff (!rst_n)
    in_hit[0] |=> (in_reg[0] == ($past(wr_data) & REG_MASK)));

  // R4: enables change only through their own address
  a_r4_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_hit |=> $stable(en_q));

endmodule

// File: rtl/rtg_unit.sv
module rtg_unit
  import rtg_pkg::*;
#(
  parameter int NUM_PORTS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic [15:0]          field,
  input  logic [NUM_REF-1:0]   div_en,
  input  logic [NUM_REF-1:0]   ref_tick,
  input  logic [NUM_PORTS-1:0] ws_rise,
  input  logic [NUM_PORTS-1:0] pin_share,
  output logic                 strobe
);

  logic [3:0]       src;
  logic [4:0]       code;
  logic [2:0]       src_idx;
  logic             is_div, code_ok, div_run, tick_sel, src_en;
  logic             terminal, ws_hit;
  logic [CNT_W-1:0] ratio, cnt;
  logic             strobe_q;

  assign src     = field[11:8];
  assign code    = field[4:0];
  assign src_idx = src[2:0];
  assign is_div  = (src < 4'(NUM_REF));
  assign code_ok = (code <= 5'(LAST_CODE));
  assign ratio   = code_ratio(code);
  assign tick_sel = is_div && ref_tick[src_idx];
  assign src_en   = is_div && div_en[src_idx];
  assign div_run  = src_en && code_ok;
  assign terminal = div_run && tick_sel && (cnt == ratio - CNT_W'(1));

  always_comb begin
    ws_hit = 1'b0;
    for (int n = 0; n < NUM_PORTS; n++) begin
      if (int'(src) == WS_BASE + n)
        ws_hit = pin_share[n] ? ws_rise[share_remap(n)] : ws_rise[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !div_run) cnt <= '0;
    else if (tick_sel)          cnt <= terminal ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= !restart && (terminal || ws_hit);
  end

  assign strobe = strobe_q;

  // R3: the count stays inside the selected ratio
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    div_run |-> (cnt < ratio));

  // R4: a disabled reference stays quiet
  a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (is_div && !src_en) |=> !strobe);

  // R5: reserved codes stay quiet
  a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (is_div && !code_ok) |=> !strobe);

  // R6: a selected word-select edge is passed on
  a_r6_ws_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_hit && !restart) |=> strobe);

  // R8: a write cycle is always followed by a quiet strobe
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !strobe);

endmodule

// File: rtl/rate_timing_gen.sv
module rate_timing_gen
  import rtg_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_PORTS = 10,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [4:0]           ref_tick,
  input  logic [NUM_PORTS-1:0] ws_in,
  input  logic [NUM_PORTS-1:0] pin_share,
  output logic [NUM_CH-1:0]    in_strobe,
  output logic [NUM_CH-1:0]    out_strobe
);

  logic [NUM_CH-1:0][15:0]  in_field, out_field;
  logic [NUM_REF-1:0]       div_en;
  logic [NUM_CH-1:0]        in_restart, out_restart;
  logic [NUM_PORTS-1:0]     ws_rise;

  rtg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_field(in_field), .out_field(out_field), .div_en(div_en),
    .in_restart(in_restart), .out_restart(out_restart)
  );

  rtg_ws_edge #(.NUM_PORTS(NUM_PORTS)) u_edge (
    .clk(clk), .rst_n(rst_n), .ws_in(ws_in), .ws_rise(ws_rise)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    rtg_unit #(.NUM_PORTS(NUM_PORTS)) u_in (
      .clk(clk), .rst_n(rst_n), .restart(in_restart[c]), .field(in_field[c]),
      .div_en(div_en), .ref_tick(ref_tick), .ws_rise(ws_rise),
      .pin_share(pin_share), .strobe(in_strobe[c])
    );
    rtg_unit #(.NUM_PORTS(NUM_PORTS)) u_out (
      .clk(clk), .rst_n(rst_n), .restart(out_restart[c]), .field(out_field[c]),
      .div_en(div_en), .ref_tick(ref_tick), .ws_rise(ws_rise),
      .pin_share(pin_share), .strobe(out_strobe[c])
    );
  end

  // R9: strobes are low in the first cycle after reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (in_strobe == '0 && out_strobe == '0));

endmodule

// File: tb/rate_timing_gen_tb.sv
module rate_timing_gen_tb;

  localparam int NCH = 4;
  localparam int NP  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [4:0]    ref_tick = '0;
  logic [NP-1:0] ws_in = '0;
  logic [NP-1:0] pin_share = '0;
  logic [NCH-1:0] in_strobe, out_strobe;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] shadow [4];

  rate_timing_gen #(.NUM_CH(NCH), .NUM_PORTS(NP), .ADDR_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ref_tick(ref_tick), .ws_in(ws_in), .pin_share(pin_share),
    .in_strobe(in_strobe), .out_strobe(out_strobe)
  );

  always #2 clk = ~clk;

  function automatic int ref_ratio(int c);
    int r;
    if (c > 29) return 0;
    r = 2;
    for (int i = 1; i <= c; i++) begin
      if (i <= 3)       r = r + 2;
      else if (i == 29) r = r * 2;
      else if (i % 2 == 0) r = (r * 3) / 2;
      else              r = (r * 4) / 3;
    end
    return r;
  endfunction

  function automatic int shared_line(int n);
    if (n == 1 || n == 2 || n == 9) return 0;
    if (n == 4) return 3;
    if (n == 8) return 7;
    return n;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // dir 0 = input bank (addr 0..1), dir 1 = output bank (addr 2..3)
  task automatic put_field(int dir, int ch, logic [15:0] f);
    int a;
    a = dir * 2 + ch / 2;
    if (ch % 2 == 1) shadow[a][31:16] = f;
    else             shadow[a][15:0]  = f;
    wr(a, shadow[a]);
  endtask

  function automatic logic unit_strobe(int u);
    return (u < NCH) ? in_strobe[u] : out_strobe[u - NCH];
  endfunction

  task automatic count_in0(int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (in_strobe[0]) n++;
    end
  endtask

  task automatic pulse_ws(int p, output int first, output int total);
    ws_in[p] = 1'b1;
    @(negedge clk);
    first = int'(in_strobe[1]);
    total = first;
    ws_in[p] = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      total += int'(in_strobe[1]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int n, f, t, lim, code, src;
    int first [2*NCH];
    int hits  [2*NCH];
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R9: quiet after reset even with all ticks high
    ref_tick = 5'h1F;
    n = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      n += int'($countones({in_strobe, out_strobe}));
    end
    chk(n == 0, "R9 reset quiet", n, 0);

    // R3/R5/R1: divider table sweep, eight codes per round
    for (int r = 0; r < 4; r++) begin
      wr(4, 32'h0);
      lim = 0;
      for (int u = 0; u < 2*NCH; u++) begin
        code = r * 8 + u;
        src  = (u + r) % 5;
        if (ref_ratio(code) > lim) lim = ref_ratio(code);
        put_field(u / NCH, u % NCH,
                  16'((src << 8) | code) | ((r == 1) ? 16'hF0E0 : 16'h0));
      end
      lim += 2;
      for (int u = 0; u < 2*NCH; u++) begin first[u] = 0; hits[u] = 0; end
      wr(4, 32'h3E);
      for (int k = 1; k <= lim; k++) begin
        @(negedge clk);
        for (int u = 0; u < 2*NCH; u++) begin
          if (unit_strobe(u)) begin
            hits[u]++;
            if (first[u] == 0) first[u] = k;
          end
        end
      end
      for (int u = 0; u < 2*NCH; u++) begin
        code = r * 8 + u;
        if (ref_ratio(code) == 0) begin
          chk(hits[u] == 0, "R5 reserved code", hits[u], 0);
        end else begin
          chk(first[u] == ref_ratio(code), "R3 first strobe / R1 field", first[u], ref_ratio(code));
          chk(hits[u] == lim / ref_ratio(code), "R3 strobe count", hits[u], lim / ref_ratio(code));
        end
      end
    end

    // R2: each source counts only its own tick
    wr(4, 32'h3E);
    for (int s = 0; s < 5; s++) begin
      ref_tick = '0;
      put_field(0, 0, 16'(s << 8));
      n = 0;
      for (int k = 0; k < 40; k++) begin
        ref_tick = (k % 4 == 0) ? 5'h1F : (5'h1F & ~(5'd1 << s));
        @(negedge clk);
        if (in_strobe[0]) n++;
      end
      chk(n == 5, "R2 source tick select", n, 5);
    end

    // R4: enable bit at source+1
    ref_tick = 5'h1F;
    put_field(0, 0, 16'h0200);
    wr(4, 32'h3E & ~32'h08);
    count_in0(20, n);
    chk(n == 0, "R4 enable clear", n, 0);
    wr(4, 32'h08);
    count_in0(20, n);
    chk(n == 10, "R4 enable set", n, 10);

    // R10: source 5 is silent
    wr(4, 32'h3E);
    put_field(0, 0, 16'h0500);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      ws_in = (k % 2 == 0) ? '1 : '0;
      @(negedge clk);
      if (in_strobe[0]) n++;
    end
    ws_in = '0;
    @(negedge clk);
    chk(n == 0, "R10 unused source", n, 0);

    // R6/R7: word-select selection and pin-share remap on channel 1
    wr(4, 32'h0);
    ref_tick = '0;
    for (int p = 0; p < NP; p++) begin
      pin_share = '0;
      put_field(0, 1, 16'((6 + p) << 8));
      pulse_ws(p, f, t);
      chk(f == 1 && t == 1, "R6 own word-select", t, 1);
      pulse_ws((p + 1) % NP, f, t);
      chk(t == 0, "R6 other word-select ignored", t, 0);
      pin_share = '1;
      pulse_ws(shared_line(p), f, t);
      chk(f == 1 && t == 1, "R7 shared word-select", t, 1);
      if (shared_line(p) != p) begin
        pulse_ws(p, f, t);
        chk(t == 0, "R7 own line ignored while shared", t, 0);
      end
    end
    pin_share = '0;

    // R8: rewrite collides with a terminal count
    ref_tick = 5'h1F;
    wr(4, 32'h3E);
    put_field(0, 0, 16'h0001);
    n = 0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (in_strobe[0]) n++;
      if (k == 4) chk(in_strobe[0] == 1'b1, "R8 strobe before collision", int'(in_strobe[0]), 1);
    end
    chk(n == 1, "R8 count before collision", n, 1);
    wr(0, shadow[0]);
    chk(in_strobe[0] == 1'b0, "R8 write beats terminal count", int'(in_strobe[0]), 0);
    f = 0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (in_strobe[0] && f == 0) f = k;
    end
    chk(f == 4, "R8 restart latency", f, 4);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule